// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

This block stretches external bus accesses by a programmable number of wait cycles. Each of four chip-select spaces has its own 3-bit wait count. The counts sit in one 16-bit control register that software can read and write. When the bus master starts an access, it presents the selected space on `acc_space_i`. The controller latches that space's count and holds the access in a wait phase for that many cycles. It then issues a one-cycle completion pulse.

A count of zero gives an access with no wait cycles, and the external wait pin has no effect on it. For a nonzero count, the active-low external wait input can lengthen the access past the programmed count.

The register has two reset classes:
- The power-on reset, and the standby request, load every count with seven.
- A manual reset only returns the access sequencer to idle and leaves the register unchanged.

Top module: `cs_wait_ctrl`

## Requirements
- R1: The control register is 16 bits, written with `reg_we_i`/`reg_wdata_i` and read on `reg_rdata_o`. The count for space k is in bits [4k+2:4k], so space 0 uses [2:0], space 1 uses [6:4], space 2 uses [10:8] and space 3 uses [14:12].
- R2: Bits 3, 7, 11 and 15 always read 0, and writes to them have no effect.
- R3: While `rst_ni` is low, the register reads 0x7777, and `acc_wait_o` and `acc_done_o` are low.
- R4: `standby_i` high at a clock edge loads the register with 0x7777. It takes priority over a write in the same cycle.
- R5: `man_rst_i` high at a clock edge returns the sequencer to idle, so `acc_wait_o` and `acc_done_o` are low after that edge. It leaves the register unchanged.
- R6: An access to a space whose count is 0 gives `acc_done_o` high in the cycle after the one in which `acc_start_i` was sampled. `acc_wait_o` stays low, and `ext_wait_ni` is ignored.
- R7: An access to a space whose count is N (1 to 7), with `ext_wait_ni` high, behaves as follows:
  - `acc_wait_o` is high for exactly N cycles, starting in the cycle after the start was sampled.
  - `acc_done_o` is high in the cycle after the last wait cycle.
- R8: `ext_wait_ni` is sampled at the end of the last programmed wait cycle and at the end of each extension cycle. Each time it is sampled low, the wait phase lasts one more cycle.
- R9: `acc_done_o` is a single-cycle pulse.
- R10: The count is latched when the access starts. A register write during an access changes only later accesses.
- R11: `acc_start_i` is ignored unless the sequencer is idle, meaning both `acc_wait_o` and `acc_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| standby_i | input | 1 | Standby request; reloads the register with all-sevens |
| man_rst_i | input | 1 | Manual reset of the sequencer; the register is kept |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| acc_start_i | input | 1 | Access start request |
| acc_space_i | input | 2 | Selected chip-select space |
| ext_wait_ni | input | 1 | Active-low external wait request |
| acc_wait_o | output | 1 | Access is in its wait phase |
| acc_done_o | output | 1 | One-cycle access-complete strobe |

## Verification
On every cycle, the assertions check the following local rules:
- the completion strobe is one cycle wide;
- a zero-count start completes on the next cycle;
- an asserted wait pin at an expired count keeps the wait phase alive;
- the programmed countdown keeps the wait phase alive;
- a manual reset clears the sequencer and leaves the register as it was;
- a standby request reloads all-sevens.

Some behaviours depend on a history of stimulus, and only the bench's scenarios show them: exact access lengths for each space and count, masking of the wait pin for zero counts, writes landing in the middle of an access, ignored starts, reserved-bit filtering, and priority of standby over a write. The bench checks these with a cycle-accurate reference model compared on every clock.

// File: rtl/cswc_pkg.sv
package cswc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } cswc_state_e;
endpackage

// File: rtl/cswc_regfile.sv
module cswc_regfile #(
  parameter int NUM_SPACES = 4,
  parameter int CNT_W      = 3,
  parameter int FIELD_W    = 4,
  localparam int REG_W     = NUM_SPACES * FIELD_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              standby_i,
  input  logic                              we_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  output logic [NUM_SPACES-1:0][CNT_W-1:0]  cnt_o
);
  localparam int RSV_W = FIELD_W - CNT_W;

  function automatic logic [REG_W-1:0] reload_val();
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SPACES; i++) v[i*FIELD_W +: CNT_W] = '1;
    return v;
  endfunction

  localparam logic [REG_W-1:0] RELOAD = reload_val();

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_field
    logic [CNT_W-1:0] field_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        field_q <= '1;
      else if (standby_i) field_q <= '1;
      else if (we_i)      field_q <= wdata_i[g*FIELD_W +: CNT_W];
    end
    assign cnt_o[g] = field_q;
    assign rdata_o[g*FIELD_W +: CNT_W] = field_q;
    if (RSV_W > 0) begin : g_rsv
      assign rdata_o[g*FIELD_W+CNT_W +: RSV_W] = '0;
    end
  end

  // standby reload, R4
  assert_standby_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (rdata_o == RELOAD));

  // no write and no standby keeps contents (covers manual reset), R5
  assert_reg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/cswc_seq.sv
module cswc_seq
  import cswc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             man_rst_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_sel_i,
  input  logic             ext_wait_ni,
  output logic             wait_o,
  output logic             done_o
);
  cswc_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (man_rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          // count latched here; later writes do not reach this access
          if (cnt_sel_i == '0) state_q <= ST_DONE;
          else begin
            state_q <= ST_WAIT;
            cnt_q   <= cnt_sel_i - 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q != '0)     cnt_q   <= cnt_q - 1'b1;
          else if (ext_wait_ni) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wait_o = (state_q == ST_WAIT);
  assign done_o = (state_q == ST_DONE);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_zero_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_o && !done_o && start_i && cnt_sel_i == '0 && !man_rst_i) |=> (done_o && !wait_o));

  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && cnt_q != '0 && !man_rst_i) |=> wait_o);

  assert_ext_extend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && cnt_q == '0 && !ext_wait_ni && !man_rst_i) |=> wait_o);

  assert_man_rst_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> (!wait_o && !done_o));
endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl #(
  parameter int NUM_SPACES = 4,
  parameter int CNT_W      = 3,
  parameter int FIELD_W    = 4,
  localparam int REG_W     = NUM_SPACES * FIELD_W,
  localparam int SEL_W     = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             man_rst_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             acc_start_i,
  input  logic [SEL_W-1:0] acc_space_i,
  input  logic             ext_wait_ni,
  output logic             acc_wait_o,
  output logic             acc_done_o
);
  logic [NUM_SPACES-1:0][CNT_W-1:0] cnt_all;
  logic [CNT_W-1:0]                 cnt_sel;

  cswc_regfile #(
    .NUM_SPACES(NUM_SPACES), .CNT_W(CNT_W), .FIELD_W(FIELD_W)
  ) u_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .standby_i(standby_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .cnt_o    (cnt_all)
  );

  always_comb begin
    cnt_sel = '0;
    for (int i = 0; i < NUM_SPACES; i++)
      if (acc_space_i == SEL_W'(i)) cnt_sel = cnt_all[i];
  end

  cswc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .man_rst_i  (man_rst_i),
    .start_i    (acc_start_i),
    .cnt_sel_i  (cnt_sel),
    .ext_wait_ni(ext_wait_ni),
    .wait_o     (acc_wait_o),
    .done_o     (acc_done_o)
  );
endmodule

// File: tb/cs_wait_ctrl_bench.sv
module cs_wait_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, man_rst = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        start = 1'b0;
  logic [1:0]  space = '0;
  logic        ext_n = 1'b1;
  logic        wait_s, done_s;

  int    errors = 0, checks = 0;
  string cur_req = "R3";

  always #4 clk = ~clk;

  cs_wait_ctrl u_cs_wait_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .man_rst_i(man_rst),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .acc_start_i(start), .acc_space_i(space), .ext_wait_ni(ext_n),
    .acc_wait_o(wait_s), .acc_done_o(done_s)
  );

  // reference model: state 0 idle, 1 waiting, 2 done
  int          m_state = 0;
  int          m_rem = 0;
  logic [15:0] m_reg = 16'h7777;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 16'h7777; m_state = 0; m_rem = 0;
    end else begin
      int n;
      n = int'((m_reg >> (4 * space)) & 16'h7);
      if (man_rst) m_state = 0;
      else case (m_state)
        0: if (start) begin
             if (n == 0) m_state = 2;
             else begin m_state = 1; m_rem = n - 1; end
           end
        1: if (m_rem > 0) m_rem--;
           else if (ext_n) m_state = 2;
        default: m_state = 0;
      endcase
      if (standby) m_reg = 16'h7777;
      else if (we) m_reg = wdata & 16'h7777;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("rdata", int'(rdata), int'(m_reg));
    chk("wait", int'(wait_s), int'(m_state == 1));
    chk("done", int'(done_s), int'(m_state == 2));
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    we = 1'b1; wdata = d; cyc(1); we = 1'b0;
  endtask

  task automatic go(input logic [1:0] s);
    start = 1'b1; space = s; cyc(1); start = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R3"; cyc(3);
    rst_n = 1'b1; cyc(2);
    cur_req = "R1"; wr(16'h0123); cyc(2);
    cur_req = "R2"; wr(16'hFFFF); cyc(1); wr(16'h8888); cyc(1);
    // counts: space0=0 space1=1 space2=3 space3=7
    cur_req = "R1"; wr(16'h7310); cyc(1);
    cur_req = "R6"; go(2'd0); cyc(3);
    ext_n = 1'b0; go(2'd0); cyc(3); ext_n = 1'b1;
    cur_req = "R7"; go(2'd1); cyc(4); go(2'd2); cyc(6); go(2'd3); cyc(10);
    cur_req = "R8"; go(2'd2); ext_n = 1'b0; cyc(5); ext_n = 1'b1; cyc(4);
    go(2'd1); ext_n = 1'b0; cyc(1); ext_n = 1'b1; cyc(4);
    cur_req = "R9"; go(2'd0); go(2'd0); cyc(3);
    cur_req = "R10"; go(2'd3); cyc(1); wr(16'h0100); cyc(10); go(2'd3); cyc(4);
    wr(16'h7310); cyc(1);
    cur_req = "R11"; go(2'd3); cyc(1); go(2'd0); cyc(1); go(2'd1); cyc(10);
    cur_req = "R5"; go(2'd3); cyc(2); man_rst = 1'b1; cyc(1); man_rst = 1'b0; cyc(3);
    go(2'd2); cyc(2); man_rst = 1'b1; we = 1'b0; cyc(2); man_rst = 1'b0; cyc(1);
    go(2'd2); cyc(6);
    cur_req = "R4"; standby = 1'b1; we = 1'b1; wdata = 16'h1234; cyc(1);
    standby = 1'b0; we = 1'b0; cyc(2);
    go(2'd0); cyc(10);
    cur_req = "R3"; rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule